// File: doc/BRIEF.md
# Valid-Bit Command Ring Tracker

This block tracks the producer side of a circular command ring of eight 64-byte slots. A producer claims a slot, fills it elsewhere, and then commits it. The tracker tells the producer which byte to write as the slot's command code. That byte carries an ownership bit whose polarity flips each time the producer cursor wraps. The tracker also reports the slot address and, when the selected notification style needs it, the new producer index to publish. The slot payloads and the bus that carries them are outside this block.

The tracker keeps the producer cursor, the current ownership polarity, a cached copy of the consumer index and the number of free slots. At most seven slots can be outstanding at one time. The consumer reports progress by handing in its new index. The tracker then credits the cyclic distance back to the free count and returns that distance. An initialisation load seeds the cursor, the polarity, the consumer index and the notification style from the ring's current hardware state. The tracker also holds an 8-bit interrupt threshold register that software can read and write.

Top module: `cmd_ring_tracker`

## Requirements
- R1: After reset: cursor 0, polarity 0, free count 7, fill level 0, not busy, config 0, threshold 0, and every pulse output low.
- R2: An init load sets the cursor to init_pi[2:0] and the polarity to init_pi[3]. It sets the cached consumer index to init_ci and the free count to 7 minus the cyclic distance from init_ci to init_pi[2:0]. It writes cfg_out[1:0] = init_mode with cfg_out[4:2] = 0 and clears busy. An init load overrides every other request in the same cycle except a threshold write.
- R3: A start while idle with a free count above zero pulses start_grant and sets busy. A start while idle with a free count of zero pulses start_deny. A start while busy pulses seq_err. In both of the last two cases the ring state is left unchanged.
- R4: A commit while busy emits verb_valid. It sets verb_out = cmd_code OR (polarity << 7) and verb_addr = cursor × 64. It advances the cursor by one, lowers the free count by one and clears busy.
- R5: Advancing the cursor from 7 to 0 inverts the polarity. Any other advance leaves the polarity unchanged.
- R6: On commit, style 0 pulses pi_wr_unc and style 1 pulses pi_wr_cac, each with pi_out set to the new cursor. Styles 2 and 3 (valid-bit only) pulse neither strobe. A pend never pulses either strobe.
- R7: A pend while busy, with no commit, a free count above 1 and a style below 2, emits the command byte and advances the cursor exactly as R4 does, but busy stays set. If instead the free count is 1 or less, or the style is 2 or 3, the pend pulses pend_deny and changes nothing.
- R8: Commit, pend and abort while idle are ignored. An abort while busy, with no commit or pend, clears busy and changes nothing else. The priority while busy is commit, then pend, then abort.
- R9: A consumer update loads ci_value, pulses ci_delta_valid and sets ci_delta to the cyclic distance from the old to the new consumer index. It adds that distance to the free count. In the same cycle it combines with an advance as free − 1 + distance.
- R10: fill_cnt always equals 7 − free_cnt.
- R11: A threshold write stores thr_wdata, which thr_out shows from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_load | input | 1 | Load ring state from hardware values |
| init_pi | input | 4 | Producer index with polarity bit in bit 3 |
| init_ci | input | 3 | Consumer index at initialisation |
| init_mode | input | 2 | Notification style |
| start_req | input | 1 | Claim the slot under the cursor |
| abort_req | input | 1 | Drop the claim |
| commit_req | input | 1 | Publish the slot and release the claim |
| pend_req | input | 1 | Publish the slot and keep the claim |
| cmd_code | input | 8 | Command code to merge with the polarity |
| ci_load | input | 1 | Consumer index update |
| ci_value | input | 3 | New consumer index |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | Threshold write data |
| start_grant | output | 1 | Start accepted |
| start_deny | output | 1 | Start refused, ring full |
| pend_deny | output | 1 | Pend refused |
| seq_err | output | 1 | Start issued while busy |
| busy | output | 1 | A slot is claimed |
| verb_valid | output | 1 | verb_out and verb_addr are valid |
| verb_out | output | 8 | Command byte to write, polarity merged |
| verb_addr | output | 9 | Byte offset of the published slot |
| pi_wr_unc | output | 1 | Write pi_out to the uncached index register |
| pi_wr_cac | output | 1 | Write pi_out to the cached index location |
| pi_out | output | 3 | New producer index |
| cursor | output | 3 | Current producer cursor |
| vbit | output | 1 | Current ownership polarity |
| free_cnt | output | 4 | Free slots |
| fill_cnt | output | 4 | Occupied slots |
| ci_delta_valid | output | 1 | ci_delta is valid |
| ci_delta | output | 4 | Slots returned by the last update |
| cfg_out | output | 5 | Config: style in [1:0], zeros above |
| thr_out | output | 8 | Interrupt threshold |

## Verification
Three behaviours are hard to reach from the ports. The first is a consumer update landing in the same cycle as an advance across the 7-to-0 boundary. The second is a pend refused on the last free slot. The third is a start refused on a full ring. To reach them, the stimulus first initialises the ring near the wrap point, then chains pends until the refusal and commits to fill the ring. After that it runs a long random phase. In that phase consumer updates advance the cached index by a random amount that never exceeds the outstanding count, so every update stays legal while collisions with advances remain frequent.

// File: rtl/ring_trk_pkg.sv
package ring_trk_pkg;

   typedef enum logic [1:0] {
      NTF_UNCACHED = 2'd0,
      NTF_CACHED   = 2'd1,
      NTF_VALIDBIT = 2'd2,
      NTF_RESERVED = 2'd3
   } notify_mode_e;

   typedef struct packed {
      logic grant;
      logic deny;
      logic seq_err;
      logic commit;
      logic pend_go;
      logic pend_deny;
      logic advance;
   } ctrl_dec_t;

endpackage

// File: rtl/ring_trk_ctrl.sv
module ring_trk_ctrl
   import ring_trk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      init_load,
   input  logic      start_req,
   input  logic      abort_req,
   input  logic      commit_req,
   input  logic      pend_req,
   input  logic      free_zero,
   input  logic      free_low,
   input  logic      vb_only,
   output ctrl_dec_t dec,
   output logic      busy
);

   logic busy_q;
   logic abort_go;

   always_comb begin
      dec           = '0;
      dec.grant     = !init_load && start_req && !busy_q && !free_zero;
      dec.deny      = !init_load && start_req && !busy_q &&  free_zero;
      dec.seq_err   = !init_load && start_req &&  busy_q;
      dec.commit    = !init_load && busy_q && commit_req;
      dec.pend_go   = !init_load && busy_q && !commit_req && pend_req &&
                      !free_low && !vb_only;
      dec.pend_deny = !init_load && busy_q && !commit_req && pend_req &&
                      (free_low || vb_only);
      dec.advance   = dec.commit || dec.pend_go;
   end

   assign abort_go = !init_load && busy_q && !commit_req && !pend_req && abort_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     busy_q <= 1'b0;
      else if (init_load)             busy_q <= 1'b0;
      else if (dec.grant)             busy_q <= 1'b1;
      else if (dec.commit || abort_go) busy_q <= 1'b0;
   end

   assign busy = busy_q;

endmodule

// File: rtl/ring_trk_cursor.sv
module ring_trk_cursor #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_idx,
   input  logic             load_vb,
   input  logic             advance,
   output logic [IDX_W-1:0] cur,
   output logic [IDX_W-1:0] cur_next,
   output logic             vb
);

   logic [IDX_W-1:0] cur_q;
   logic             vb_q;
   logic             carry;

   assign {carry, cur_next} = {1'b0, cur_q} + {{IDX_W{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         vb_q  <= 1'b0;
      end else if (load) begin
         cur_q <= load_idx;
         vb_q  <= load_vb;
      end else if (advance) begin
         cur_q <= cur_next;
         vb_q  <= vb_q ^ carry;
      end
   end

   assign cur = cur_q;
   assign vb  = vb_q;

endmodule

// File: rtl/ring_trk_credit.sv
module ring_trk_credit #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_ci,
   input  logic [IDX_W-1:0] load_pi,
   input  logic             ci_load,
   input  logic [IDX_W-1:0] ci_value,
   input  logic             advance,
   output logic [IDX_W:0]   free_cnt,
   output logic             delta_valid,
   output logic [IDX_W:0]   delta
);

   localparam int            DEPTH    = 1 << IDX_W;
   localparam logic [IDX_W:0] DEPTH_V  = (IDX_W+1)'(DEPTH);
   localparam logic [IDX_W:0] MAX_FREE = (IDX_W+1)'(DEPTH - 1);

   function automatic logic [IDX_W:0] cyc_dist(input logic [IDX_W-1:0] first,
                                                input logic [IDX_W-1:0] last);
      if (first <= last) return {1'b0, last} - {1'b0, first};
      else               return DEPTH_V + {1'b0, last} - {1'b0, first};
   endfunction

   logic [IDX_W-1:0] ci_q;
   logic [IDX_W:0]   free_q;
   logic [IDX_W:0]   gain;

   assign gain = ci_load ? cyc_dist(ci_q, ci_value) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ci_q        <= '0;
         free_q      <= MAX_FREE;
         delta_valid <= 1'b0;
         delta       <= '0;
      end else if (load) begin
         ci_q        <= load_ci;
         free_q      <= MAX_FREE - cyc_dist(load_ci, load_pi);
         delta_valid <= 1'b0;
      end else begin
         if (ci_load) ci_q <= ci_value;
         free_q      <= free_q + gain - {{IDX_W{1'b0}}, advance};
         delta_valid <= ci_load;
         if (ci_load) delta <= gain;
      end
   end

   assign free_cnt = free_q;

endmodule

// File: rtl/cmd_ring_tracker.sv
module cmd_ring_tracker
   import ring_trk_pkg::*;
#(
   parameter int IDX_W      = 3,
   parameter int SLOT_SHIFT = 6,
   parameter int VERB_W     = 8,
   parameter int THR_W      = 8,
   parameter int CFG_W      = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      init_load,
   input  logic [IDX_W:0]            init_pi,
   input  logic [IDX_W-1:0]          init_ci,
   input  logic [1:0]                init_mode,
   input  logic                      start_req,
   input  logic                      abort_req,
   input  logic                      commit_req,
   input  logic                      pend_req,
   input  logic [VERB_W-1:0]         cmd_code,
   input  logic                      ci_load,
   input  logic [IDX_W-1:0]          ci_value,
   input  logic                      thr_we,
   input  logic [THR_W-1:0]          thr_wdata,
   output logic                      start_grant,
   output logic                      start_deny,
   output logic                      pend_deny,
   output logic                      seq_err,
   output logic                      busy,
   output logic                      verb_valid,
   output logic [VERB_W-1:0]         verb_out,
   output logic [IDX_W+SLOT_SHIFT-1:0] verb_addr,
   output logic                      pi_wr_unc,
   output logic                      pi_wr_cac,
   output logic [IDX_W-1:0]          pi_out,
   output logic [IDX_W-1:0]          cursor,
   output logic                      vbit,
   output logic [IDX_W:0]            free_cnt,
   output logic [IDX_W:0]            fill_cnt,
   output logic                      ci_delta_valid,
   output logic [IDX_W:0]            ci_delta,
   output logic [CFG_W-1:0]          cfg_out,
   output logic [THR_W-1:0]          thr_out
);

   localparam int             ADDR_W   = IDX_W + SLOT_SHIFT;
   localparam int             DEPTH    = 1 << IDX_W;
   localparam logic [IDX_W:0] MAX_FREE = (IDX_W+1)'(DEPTH - 1);

   if (IDX_W < 2 || IDX_W > 8) begin : g_bad_idx
      $error("IDX_W must lie in 2..8");
   end
   if (VERB_W < 2) begin : g_bad_verb
      $error("VERB_W must be at least 2");
   end
   if (CFG_W < 2) begin : g_bad_cfg
      $error("CFG_W must hold the 2-bit style");
   end

   ctrl_dec_t        dec;
   notify_mode_e     mode_q;
   logic [IDX_W-1:0] cur_next;
   logic [ADDR_W-1:0] slot_addr;

   ring_trk_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_load  (init_load),
      .start_req  (start_req),
      .abort_req  (abort_req),
      .commit_req (commit_req),
      .pend_req   (pend_req),
      .free_zero  (free_cnt == '0),
      .free_low   (free_cnt <= (IDX_W+1)'(1)),
      .vb_only    (mode_q[1]),
      .dec        (dec),
      .busy       (busy)
   );

   ring_trk_cursor #(.IDX_W(IDX_W)) u_cursor (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (init_load),
      .load_idx (init_pi[IDX_W-1:0]),
      .load_vb  (init_pi[IDX_W]),
      .advance  (dec.advance),
      .cur      (cursor),
      .cur_next (cur_next),
      .vb       (vbit)
   );

   ring_trk_credit #(.IDX_W(IDX_W)) u_credit (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (init_load),
      .load_ci     (init_ci),
      .load_pi     (init_pi[IDX_W-1:0]),
      .ci_load     (ci_load),
      .ci_value    (ci_value),
      .advance     (dec.advance),
      .free_cnt    (free_cnt),
      .delta_valid (ci_delta_valid),
      .delta       (ci_delta)
   );

   if (SLOT_SHIFT > 0) begin : g_slot_shift
      assign slot_addr = {cursor, {SLOT_SHIFT{1'b0}}};
   end else begin : g_slot_flat
      assign slot_addr = cursor;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= NTF_UNCACHED;
         thr_out     <= '0;
         start_grant <= 1'b0;
         start_deny  <= 1'b0;
         pend_deny   <= 1'b0;
         seq_err     <= 1'b0;
         verb_valid  <= 1'b0;
         verb_out    <= '0;
         verb_addr   <= '0;
         pi_wr_unc   <= 1'b0;
         pi_wr_cac   <= 1'b0;
         pi_out      <= '0;
      end else begin
         if (init_load) mode_q <= notify_mode_e'(init_mode);
         if (thr_we)    thr_out <= thr_wdata;
         start_grant <= dec.grant;
         start_deny  <= dec.deny;
         pend_deny   <= dec.pend_deny;
         seq_err     <= dec.seq_err;
         verb_valid  <= dec.advance;
         pi_wr_unc   <= dec.commit && (mode_q == NTF_UNCACHED);
         pi_wr_cac   <= dec.commit && (mode_q == NTF_CACHED);
         if (dec.advance) begin
            verb_out  <= cmd_code | {vbit, {(VERB_W-1){1'b0}}};
            verb_addr <= slot_addr;
         end
         if (dec.commit && !mode_q[1]) pi_out <= cur_next;
      end
   end

   assign fill_cnt = MAX_FREE - free_cnt;
   assign cfg_out  = {{(CFG_W-2){1'b0}}, mode_q};

endmodule

// File: rtl/ring_trk_checker.sv
module ring_trk_checker #(
   parameter int IDX_W      = 3,
   parameter int SLOT_SHIFT = 6,
   parameter int VERB_W     = 8,
   parameter int CFG_W      = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [VERB_W-1:0]           cmd_code,
   input logic                        start_grant,
   input logic                        busy,
   input logic                        verb_valid,
   input logic [VERB_W-1:0]           verb_out,
   input logic [IDX_W+SLOT_SHIFT-1:0] verb_addr,
   input logic                        pi_wr_unc,
   input logic                        pi_wr_cac,
   input logic [CFG_W-1:0]            cfg_out,
   input logic                        pend_deny,
   input logic                        vbit,
   input logic [IDX_W:0]              free_cnt,
   input logic [IDX_W:0]              fill_cnt,
   input logic                        ci_delta_valid
);

   localparam logic [IDX_W:0]   MAX_FREE = (IDX_W+1)'((1 << IDX_W) - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

   p_credit_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= MAX_FREE);

   p_fill_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_cnt + free_cnt) == MAX_FREE);

   p_grant_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_grant |-> busy);

   p_verb_polarity_r4: assert property (@(posedge clk) disable iff (!rst_n)
      verb_valid |-> verb_out[VERB_W-1] == ($past(vbit) | $past(cmd_code[VERB_W-1])));

   p_free_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (verb_valid && !ci_delta_valid) |-> (free_cnt + (IDX_W+1)'(1)) == $past(free_cnt));

   p_wrap_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (verb_valid && verb_addr[IDX_W+SLOT_SHIFT-1:SLOT_SHIFT] == LAST_IDX)
         |-> vbit != $past(vbit));

   p_notify_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pi_wr_unc || pi_wr_cac) |-> (!(pi_wr_unc && pi_wr_cac) && !cfg_out[1]));

   p_pend_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_deny |-> ($past(free_cnt) <= (IDX_W+1)'(1) || cfg_out[1]));

endmodule

bind cmd_ring_tracker ring_trk_checker #(
   .IDX_W(IDX_W), .SLOT_SHIFT(SLOT_SHIFT), .VERB_W(VERB_W), .CFG_W(CFG_W)
) u_ring_trk_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_code       (cmd_code),
   .start_grant    (start_grant),
   .busy           (busy),
   .verb_valid     (verb_valid),
   .verb_out       (verb_out),
   .verb_addr      (verb_addr),
   .pi_wr_unc      (pi_wr_unc),
   .pi_wr_cac      (pi_wr_cac),
   .cfg_out        (cfg_out),
   .pend_deny      (pend_deny),
   .vbit           (vbit),
   .free_cnt       (free_cnt),
   .fill_cnt       (fill_cnt),
   .ci_delta_valid (ci_delta_valid)
);

// File: tb/test_cmd_ring_tracker.sv
module test_cmd_ring_tracker;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       init_load = 1'b0;
   logic [3:0] init_pi = '0;
   logic [2:0] init_ci = '0;
   logic [1:0] init_mode = '0;
   logic       start_req = 1'b0, abort_req = 1'b0, commit_req = 1'b0, pend_req = 1'b0;
   logic [7:0] cmd_code = '0;
   logic       ci_load = 1'b0;
   logic [2:0] ci_value = '0;
   logic       thr_we = 1'b0;
   logic [7:0] thr_wdata = '0;

   logic       start_grant, start_deny, pend_deny, seq_err, busy;
   logic       verb_valid, pi_wr_unc, pi_wr_cac, vbit, ci_delta_valid;
   logic [7:0] verb_out, thr_out;
   logic [8:0] verb_addr;
   logic [2:0] pi_out, cursor;
   logic [3:0] free_cnt, fill_cnt, ci_delta;
   logic [4:0] cfg_out;

   cmd_ring_tracker i_cmd_ring_tracker (
      .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_pi(init_pi),
      .init_ci(init_ci), .init_mode(init_mode), .start_req(start_req),
      .abort_req(abort_req), .commit_req(commit_req), .pend_req(pend_req),
      .cmd_code(cmd_code), .ci_load(ci_load), .ci_value(ci_value),
      .thr_we(thr_we), .thr_wdata(thr_wdata), .start_grant(start_grant),
      .start_deny(start_deny), .pend_deny(pend_deny), .seq_err(seq_err),
      .busy(busy), .verb_valid(verb_valid), .verb_out(verb_out),
      .verb_addr(verb_addr), .pi_wr_unc(pi_wr_unc), .pi_wr_cac(pi_wr_cac),
      .pi_out(pi_out), .cursor(cursor), .vbit(vbit), .free_cnt(free_cnt),
      .fill_cnt(fill_cnt), .ci_delta_valid(ci_delta_valid), .ci_delta(ci_delta),
      .cfg_out(cfg_out), .thr_out(thr_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int nvec = 0;
   int nfail = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   task automatic chk(input string req, input string what, input int got, input int exp);
      nvec++;
      if (got != exp) begin
         nfail++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   // behavioural reference state
   int m_cur = 0, m_vb = 0, m_ci = 0, m_free = 7, m_mode = 0, m_thr = 0;
   int m_busy = 0;
   int e_grant = 0, e_deny = 0, e_pdeny = 0, e_err = 0;
   int e_vv = 0, e_verb = 0, e_addr = 0;
   int e_unc = 0, e_cac = 0, e_pi = 0, e_dv = 0, e_d = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cur = 0; m_vb = 0; m_ci = 0; m_free = 7; m_mode = 0; m_thr = 0; m_busy = 0;
         e_grant = 0; e_deny = 0; e_pdeny = 0; e_err = 0; e_vv = 0;
         e_unc = 0; e_cac = 0; e_dv = 0;
      end else begin
         int adv;
         int nb;
         e_grant = 0; e_deny = 0; e_pdeny = 0; e_err = 0; e_vv = 0;
         e_unc = 0; e_cac = 0; e_dv = 0;
         if (thr_we) m_thr = thr_wdata;
         if (init_load) begin
            m_cur  = init_pi[2:0];
            m_vb   = init_pi[3];
            m_ci   = init_ci;
            m_free = 7 - ((m_cur - m_ci + 8) % 8);
            m_mode = init_mode;
            m_busy = 0;
         end else begin
            adv = 0;
            nb  = m_busy;
            if (start_req) begin
               if (m_busy != 0) e_err = 1;
               else if (m_free == 0) e_deny = 1;
               else begin e_grant = 1; nb = 1; end
            end
            if (m_busy != 0) begin
               if (commit_req) begin
                  adv = 1; nb = 0;
                  if (m_mode == 0) e_unc = 1;
                  if (m_mode == 1) e_cac = 1;
                  e_pi = (m_cur + 1) % 8;
               end else if (pend_req) begin
                  if (m_free > 1 && m_mode < 2) adv = 1;
                  else e_pdeny = 1;
               end else if (abort_req) nb = 0;
            end
            if (adv != 0) begin
               e_vv   = 1;
               e_verb = cmd_code | (m_vb << 7);
               e_addr = m_cur * 64;
            end
            if (ci_load) begin
               e_dv = 1;
               e_d  = (ci_value - m_ci + 8) % 8;
               m_ci = ci_value;
               m_free = m_free + e_d;
            end
            m_free = m_free - adv;
            if (adv != 0) begin
               if (m_cur == 7) m_vb = 1 - m_vb;
               m_cur = (m_cur + 1) % 8;
            end
            m_busy = nb;
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk("R4", "cursor", cursor, m_cur);
         chk("R5", "vbit", vbit, m_vb);
         chk("R9", "free_cnt", free_cnt, m_free);
         chk("R10", "fill_cnt", fill_cnt, 7 - m_free);
         chk("R3", "busy", busy, m_busy);
         chk("R3", "start_grant", start_grant, e_grant);
         chk("R3", "start_deny", start_deny, e_deny);
         chk("R3", "seq_err", seq_err, e_err);
         chk("R7", "pend_deny", pend_deny, e_pdeny);
         chk("R4", "verb_valid", verb_valid, e_vv);
         if (e_vv != 0) begin
            chk("R4", "verb_out", verb_out, e_verb);
            chk("R4", "verb_addr", verb_addr, e_addr);
         end
         chk("R6", "pi_wr_unc", pi_wr_unc, e_unc);
         chk("R6", "pi_wr_cac", pi_wr_cac, e_cac);
         if (e_unc != 0 || e_cac != 0) chk("R6", "pi_out", pi_out, e_pi);
         chk("R9", "ci_delta_valid", ci_delta_valid, e_dv);
         if (e_dv != 0) chk("R9", "ci_delta", ci_delta, e_d);
         chk("R2", "cfg_out", cfg_out, m_mode);
         chk("R11", "thr_out", thr_out, m_thr);
      end
   end

   task automatic clear_in();
      init_load = 0; start_req = 0; abort_req = 0; commit_req = 0; pend_req = 0;
      ci_load = 0; thr_we = 0;
   endtask

   task automatic cyc(input int s, input int a, input int c, input int p, input int code);
      start_req = s[0]; abort_req = a[0]; commit_req = c[0]; pend_req = p[0];
      cmd_code = code[7:0];
      @(negedge clk);
      clear_in();
   endtask

   task automatic do_init(input int pi, input int ci, input int mode);
      init_load = 1; init_pi = pi[3:0]; init_ci = ci[2:0]; init_mode = mode[1:0];
      @(negedge clk);
      clear_in();
   endtask

   task automatic do_ci(input int v);
      ci_load = 1; ci_value = v[2:0];
      @(negedge clk);
      clear_in();
   endtask

   initial begin : watchdog
      int n;
      n = 0;
      while (!done && n < WATCHDOG) begin
         @(posedge clk);
         n++;
      end
      if (!done) begin
         nvec++; nfail++;
         $display("FAIL watchdog: got %0d cycles expected fewer than %0d", n, WATCHDOG);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      chk("R1", "cursor", cursor, 0);
      chk("R1", "vbit", vbit, 0);
      chk("R1", "free_cnt", free_cnt, 7);
      chk("R1", "fill_cnt", fill_cnt, 0);
      chk("R1", "busy", busy, 0);
      chk("R1", "cfg_out", cfg_out, 0);
      chk("R1", "thr_out", thr_out, 0);
      chk("R1", "verb_valid", verb_valid, 0);
      rst_n = 1;
      @(negedge clk);
      cmp_on = 1;

      // R8: producer ops while idle change nothing
      cyc(0, 0, 1, 0, 8'h11);
      cyc(0, 0, 0, 1, 8'h12);
      cyc(0, 1, 0, 0, 8'h13);
      chk("R8", "cursor after idle ops", cursor, 0);
      chk("R8", "free after idle ops", free_cnt, 7);
      chk("R8", "verb_valid after idle ops", verb_valid, 0);

      // R2: init near the wrap point, polarity 1, uncached style
      do_init(4'b1110, 3, 0);
      chk("R2", "init cursor", cursor, 6);
      chk("R2", "init vbit", vbit, 1);
      chk("R2", "init free", free_cnt, 4);

      // R4/R5/R6: commits across the wrap
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 1, 0, 8'h05);
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 1, 0, 8'h06);
      chk("R5", "polarity after wrap", vbit, 0);

      // R3/R7: fill with pends until refused, start refused when full
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 8'h21);
      cyc(0, 0, 0, 1, 8'h22);
      cyc(0, 0, 0, 1, 8'h23);
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 1, 0, 8'h24);
      chk("R3", "ring full", free_cnt, 0);
      cyc(1, 0, 0, 0, 0);

      // R9: consumer update together with a later commit
      do_ci(7);
      cyc(1, 0, 0, 0, 0);
      ci_load = 1; ci_value = 3'd2;
      cyc(0, 0, 1, 0, 8'h31);

      // R3/R8: start while busy, abort
      cyc(1, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0);

      // R6/R7: cached style, then valid-bit style
      do_init(4'b0010, 0, 1);
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 1, 0, 8'h41);
      do_init(4'b1101, 4, 2);
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 8'h51);
      cyc(0, 0, 1, 0, 8'h52);

      // R11: threshold
      thr_we = 1; thr_wdata = 8'hA5;
      @(negedge clk);
      clear_in();

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         start_req  = ($urandom_range(0, 99) < 35);
         commit_req = ($urandom_range(0, 99) < 30);
         pend_req   = ($urandom_range(0, 99) < 20);
         abort_req  = ($urandom_range(0, 99) < 5);
         cmd_code   = 8'($urandom_range(0, 255));
         if ($urandom_range(0, 99) < 30) begin
            ci_load  = 1;
            ci_value = 3'((m_ci + $urandom_range(0, 7 - m_free)) % 8);
         end
         if ($urandom_range(0, 99) < 5) begin
            thr_we = 1; thr_wdata = 8'($urandom_range(0, 255));
         end
         if (r < 2) begin
            init_load = 1;
            init_pi   = 4'($urandom_range(0, 15));
            init_ci   = 3'($urandom_range(0, 7));
            init_mode = 2'($urandom_range(0, 3));
         end
         @(negedge clk);
         clear_in();
      end

      repeat (2) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule